// File: doc/BRIEF.md
# Keystream Mode Register and Output Packer

This block sits between the host and a keystream generator core. It holds the 64-bit mode word that programs the generator and checks every write against the legal field combinations. Illegal values and writes that land while the core is busy are refused and reported on two separate sticky error outputs. The mode word reads back unchanged on a dedicated read port.

On the output side the block takes generated keystream one bit per strobed cycle and packs it into 64-bit words that the host pops from a small first-in first-out queue. A frame is 228 bits long. When the block-split bit of the mode word is set, the frame is treated as two 114-bit blocks, and each block takes two words: 64 bits, then 50 bits with zero padding. When the bit is clear, the 228 bits run on contiguously across four words, and the last word carries 36 bits.

Top module: `ks_mode_packer`

## Requirements
- R1: While `rst_n` is sampled low on a rising clock edge, the block clears the mode word, both error flags, the underflow flag, the queue and any partly built word. Afterwards `cfg_rd_data`, `fifo_rdata`, `err_data`, `err_context` and `fifo_underflow` all read zero.
- R2: Bits 63 down to 8 and bit 2 of the mode word are reserved (bit 0 is the least significant bit). A write with `core_busy` low that sets any reserved bit leaves the mode word unchanged and sets `err_data`.
- R3: Bit 7 is block-split and bit 5 is the alternate-mode bit. A write with `core_busy` low that sets both of them leaves the mode word unchanged and sets `err_data`.
- R4: A write while `core_busy` is high leaves the mode word unchanged and sets `err_context`. This holds even for a value that is illegal, and `err_data` is not set by that write.
- R5: A legal write with `core_busy` low stores the value, and `cfg_rd_data` shows it from the next cycle on. Bits 6, 4 and 3 are plain option flags and bits 1:0 select the algorithm.
- R6: With bit 7 set, stream bits 0-63 form word 1 and bits 64-113 form word 2. Bits 114-177 form word 3 and bits 178-227 form word 4. The earliest bit of each word sits in bit 63, and bits 13:0 of words 2 and 4 are zero.
- R7: With bit 7 clear, stream bits 0-63, 64-127 and 128-191 form words 1 to 3. Bits 192-227 form word 4 in bits 63:28, with bits 27:0 zero. The earliest bit of each word sits in bit 63.
- R8: A completed word is visible on `fifo_rdata` from the cycle after the edge that accepted its final bit. A `fifo_rd` strobe pops the head word. Words leave in the order they were completed, across frame boundaries.
- R9: While the queue is empty, `fifo_rdata` reads zero. A `fifo_rd` strobe on an empty queue sets `fifo_underflow`.
- R10: `err_data`, `err_context` and `fifo_underflow` stay set until reset. `reinit` does not clear them.
- R11: A `reinit` pulse clears the mode word, discards the queue and any partly built word, and restarts the frame at stream bit 0. Writes, stream bits and reads in the same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reinit | input | 1 | Re-initialise mode word, queue and packer |
| cfg_wr_en | input | 1 | Mode word write strobe |
| cfg_wr_data | input | 64 | Mode word write value |
| cfg_rd_data | output | 64 | Current mode word |
| core_busy | input | 1 | Generator core is processing |
| ks_valid | input | 1 | Keystream bit strobe |
| ks_bit | input | 1 | Keystream bit |
| fifo_rd | input | 1 | Pop the head word |
| fifo_rdata | output | 64 | Head word, zero when empty |
| err_data | output | 1 | Sticky illegal-value error |
| err_context | output | 1 | Sticky write-while-busy error |
| fifo_underflow | output | 1 | Sticky read-while-empty flag |

## Verification
Several kinds of internal fault show up at the ports:
- A wrong frame position or word-fill count shows on `fifo_rdata` as soon as the affected word reaches the head of the queue. Typical symptoms are a misplaced split point, a shifted bit or padding that is not zero.
- A wrong queue pointer shows as a repeated or skipped word on the next pop.
- A mode word updated when it should have been refused differs on `cfg_rd_data` one cycle after the write.

The reference model compares every output on every clock, so each of these faults is caught within one cycle of becoming observable.

// File: rtl/ks_pkg.sv
// Package: shared constants and the mode word layout for the keystream
// mode register and output packer. Assumes bit 0 is the least significant bit.
package ks_pkg;

    localparam int unsigned MODE_W     = 64;
    localparam int unsigned FRAME_BITS = 228;
    localparam int unsigned BLOCK_BITS = 114;

    localparam int unsigned SPLIT_POS  = 7;
    localparam int unsigned ALT_POS    = 5;

    // Reserved bits: 63..8 and 2
    localparam logic [MODE_W-1:0] RSV_MASK = 64'hFFFF_FFFF_FFFF_FF04;

    typedef struct packed {
        logic [55:0] rsv_hi;
        logic        split;
        logic        icv_check;
        logic        alt_mode;
        logic        opt_p;
        logic        opt_i;
        logic        rsv_lo;
        logic [1:0]  alg;
    } ks_mode_t;

endpackage

// File: rtl/ks_mode_reg.sv
// Module: holds the mode word, refuses illegal or busy-time writes and
// raises sticky error flags. Assumes one write per strobed cycle.
module ks_mode_reg
    import ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              busy,
    output ks_mode_t          mode,
    output logic              err_data,
    output logic              err_ctx
);

    logic illegal;

    // Decide whether a write value breaks the field rules
    always_comb begin
        illegal = (|(wr_data & RSV_MASK)) | (wr_data[SPLIT_POS] & wr_data[ALT_POS]);
    end

    // Update the mode word or record the reason it was refused
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= '0;
            err_data <= 1'b0;
            err_ctx  <= 1'b0;
        end else if (reinit) begin
            mode <= '0;
        end else if (wr_en) begin
            if (busy) begin
                err_ctx <= 1'b1;
            end else if (illegal) begin
                err_data <= 1'b1;
            end else begin
                mode <= ks_mode_t'(wr_data);
            end
        end
    end

endmodule

// File: rtl/ks_bit_packer.sv
// Module: gathers serial keystream bits into words, earliest bit in the MSB.
// Closes a word when full, at the frame end, or at the block end in split mode.
// Assumes the split setting is constant within a frame.
module ks_bit_packer #(
    parameter int unsigned WORD_W     = 64,
    parameter int unsigned FRAME_BITS = 228,
    parameter int unsigned BLOCK_BITS = 114
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit,
    input  logic              split,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_data
);

    localparam int unsigned POS_W  = $clog2(FRAME_BITS);
    localparam int unsigned FILL_W = $clog2(WORD_W);

    logic [WORD_W-1:0] acc;
    logic [FILL_W-1:0] fill;
    logic [POS_W-1:0]  pos;
    logic [FILL_W-1:0] fill_rev;
    logic              frame_end;
    logic              word_end;

    // Place the incoming bit and detect the word boundary
    always_comb begin
        fill_rev  = FILL_W'(WORD_W - 1) - fill;
        word_data = acc | ({{(WORD_W-1){1'b0}}, bit_in} << fill_rev);
        frame_end = (pos == POS_W'(FRAME_BITS - 1));
        word_end  = (fill == FILL_W'(WORD_W - 1)) || frame_end
                    || (split && (pos == POS_W'(BLOCK_BITS - 1)));
        word_vld  = bit_vld && word_end;
    end

    // Advance the partial word, fill count and frame position
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) begin
            acc  <= '0;
            fill <= '0;
            pos  <= '0;
        end else if (bit_vld) begin
            if (word_end) begin
                acc  <= '0;
                fill <= '0;
            end else begin
                acc  <= word_data;
                fill <= fill + 1'b1;
            end
            pos <= frame_end ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/ks_word_fifo.sv
// Module: show-ahead word queue with a sticky underflow flag.
// Assumes DEPTH is a power of two. A push while full is dropped.
module ks_word_fifo #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reinit,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             underflow
);

    localparam int unsigned AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp;
    logic [AW-1:0]    rp;
    logic [AW:0]      cnt;
    logic             full;
    logic             do_push;
    logic             do_pop;

    // Derive queue status and the visible head word
    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == (AW+1)'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = empty ? '0 : mem[rp];
    end

    // Store pushed words
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= push_data;
        end
    end

    // Move pointers, keep the count and latch underflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp        <= '0;
            rp        <= '0;
            cnt       <= '0;
            underflow <= 1'b0;
        end else if (reinit) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
            if (pop && empty) underflow <= 1'b1;
        end
    end

endmodule

// File: rtl/ks_mode_packer.sv
// Module: top of the keystream mode register and output packer.
// Joins the mode register, the bit packer and the output queue.
module ks_mode_packer
    import ks_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit,
    input  logic              cfg_wr_en,
    input  logic [MODE_W-1:0] cfg_wr_data,
    output logic [MODE_W-1:0] cfg_rd_data,
    input  logic              core_busy,
    input  logic              ks_valid,
    input  logic              ks_bit,
    input  logic              fifo_rd,
    output logic [MODE_W-1:0] fifo_rdata,
    output logic              err_data,
    output logic              err_context,
    output logic              fifo_underflow
);

    ks_mode_t          mode;
    logic              word_vld;
    logic [MODE_W-1:0] word_data;
    logic              q_empty;

    ks_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .reinit   (reinit),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .busy     (core_busy),
        .mode     (mode),
        .err_data (err_data),
        .err_ctx  (err_context)
    );

    ks_bit_packer #(
        .WORD_W     (MODE_W),
        .FRAME_BITS (FRAME_BITS),
        .BLOCK_BITS (BLOCK_BITS)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .reinit    (reinit),
        .split     (mode.split),
        .bit_vld   (ks_valid),
        .bit_in    (ks_bit),
        .word_vld  (word_vld),
        .word_data (word_data)
    );

    ks_word_fifo #(
        .WIDTH (MODE_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .reinit    (reinit),
        .push      (word_vld),
        .push_data (word_data),
        .pop       (fifo_rd),
        .head      (fifo_rdata),
        .empty     (q_empty),
        .underflow (fifo_underflow)
    );

    // Expose the stored mode word on the read port
    always_comb begin
        cfg_rd_data = MODE_W'(mode);
    end

endmodule

// File: rtl/ks_mode_packer_chk.sv
// Module: assertion checker bound to the top module.
// Assumes synchronous active-low reset.
module ks_mode_packer_chk
    import ks_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reinit,
    input logic              cfg_wr_en,
    input logic [MODE_W-1:0] cfg_wr_data,
    input logic              core_busy,
    input logic              fifo_rd,
    input logic              q_empty,
    input logic [MODE_W-1:0] cfg_rd_data,
    input logic              err_data,
    input logic              err_context,
    input logic              fifo_underflow
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg_rd_data == '0 && !err_data && !err_context && !fifo_underflow));

    assert_reserved_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !core_busy && !reinit && (|(cfg_wr_data & RSV_MASK)))
        |=> (err_data && $stable(cfg_rd_data)));

    assert_split_alt_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !core_busy && !reinit && cfg_wr_data[SPLIT_POS] && cfg_wr_data[ALT_POS])
        |=> (err_data && $stable(cfg_rd_data)));

    assert_busy_write_ctx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && core_busy && !reinit) |=> err_context);

    assert_busy_mode_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_busy && !reinit) |=> $stable(cfg_rd_data));

    assert_empty_read_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && q_empty && !reinit) |=> fifo_underflow);

    assert_err_data_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_data |=> err_data);

    assert_err_ctx_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_context |=> err_context);

    assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_underflow |=> fifo_underflow);

    assert_reinit_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (cfg_rd_data == '0));

endmodule

bind ks_mode_packer ks_mode_packer_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reinit         (reinit),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_wr_data    (cfg_wr_data),
    .core_busy      (core_busy),
    .fifo_rd        (fifo_rd),
    .q_empty        (q_empty),
    .cfg_rd_data    (cfg_rd_data),
    .err_data       (err_data),
    .err_context    (err_context),
    .fifo_underflow (fifo_underflow)
);

// File: tb/ks_mode_packer_tb.sv
`timescale 1ns/1ps
module ks_mode_packer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reinit = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [63:0] cfg_wr_data = '0;
    logic [63:0] cfg_rd_data;
    logic        core_busy = 1'b0;
    logic        ks_valid = 1'b0;
    logic        ks_bit = 1'b0;
    logic        fifo_rd = 1'b0;
    logic [63:0] fifo_rdata;
    logic        err_data;
    logic        err_context;
    logic        fifo_underflow;

    always #2.5 clk = ~clk;

    ks_mode_packer u_dut (
        .clk(clk), .rst_n(rst_n), .reinit(reinit),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .core_busy(core_busy), .ks_valid(ks_valid), .ks_bit(ks_bit),
        .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
        .err_data(err_data), .err_context(err_context), .fifo_underflow(fifo_underflow)
    );

    // Reference model state
    localparam logic [63:0] M_RSV = 64'hFFFF_FFFF_FFFF_FF04;
    logic [63:0] m_mode = '0;
    bit          m_derr = 0, m_ctx = 0, m_unf = 0;
    logic [63:0] m_q[$];
    bit          m_fb[228];
    int          m_pos = 0;
    bit          started = 0;
    string       tag = "R1";
    int          nvec = 0, nfail = 0, ncyc = 0;

    function automatic bit is_end(int p, bit g);
        if (g) return (p == 63 || p == 113 || p == 177 || p == 227);
        return (p == 63 || p == 127 || p == 191 || p == 227);
    endfunction

    function automatic int start_of(int p, bit g);
        if (p == 63) return 0;
        if (g) return (p == 113) ? 64 : (p == 177) ? 114 : 178;
        return (p == 127) ? 64 : (p == 191) ? 128 : 192;
    endfunction

    function automatic logic [63:0] build(int p, bit g);
        logic [63:0] w = '0;
        int s = start_of(p, g);
        for (int k = s; k <= p; k++) w[63 - (k - s)] = m_fb[k];
        return w;
    endfunction

    // Advance the model on each rising edge from the inputs held there
    always @(posedge clk) begin
        bit g;
        started = 1;
        ncyc++;
        if (!rst_n) begin
            m_mode = '0; m_derr = 0; m_ctx = 0; m_unf = 0; m_q.delete(); m_pos = 0;
        end else if (reinit) begin
            m_mode = '0; m_q.delete(); m_pos = 0;
        end else begin
            g = m_mode[7];
            if (fifo_rd) begin
                if (m_q.size() > 0) void'(m_q.pop_front());
                else m_unf = 1;
            end
            if (ks_valid) begin
                m_fb[m_pos] = ks_bit;
                if (is_end(m_pos, g)) m_q.push_back(build(m_pos, g));
                m_pos = (m_pos == 227) ? 0 : m_pos + 1;
            end
            if (cfg_wr_en) begin
                if (core_busy) m_ctx = 1;
                else if ((cfg_wr_data & M_RSV) != 0 || (cfg_wr_data[7] && cfg_wr_data[5])) m_derr = 1;
                else m_mode = cfg_wr_data;
            end
        end
    end

    // Compare every output at the falling edge
    always @(negedge clk) begin
        logic [63:0] exp_rd;
        if (started) begin
            exp_rd = (m_q.size() > 0) ? m_q[0] : 64'h0;
            nvec++;
            if (cfg_rd_data !== m_mode || fifo_rdata !== exp_rd || err_data !== m_derr
                || err_context !== m_ctx || fifo_underflow !== m_unf) begin
                nfail++;
                $display("FAIL %s t=%0t: got mode=%h rd=%h derr=%b ctx=%b unf=%b exp mode=%h rd=%h derr=%b ctx=%b unf=%b",
                         tag, $time, cfg_rd_data, fifo_rdata, err_data, err_context, fifo_underflow,
                         m_mode, exp_rd, m_derr, m_ctx, m_unf);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (ncyc > 50000) begin
            nfail++;
            $display("FAIL %s watchdog: got running exp finished", tag);
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; idle(2); rst_n = 1; idle(1);
    endtask

    task automatic wr(logic [63:0] d, bit busy);
        cfg_wr_en = 1; cfg_wr_data = d; core_busy = busy;
        @(negedge clk);
        cfg_wr_en = 0; core_busy = 0;
    endtask

    task automatic rd(int n);
        for (int i = 0; i < n; i++) begin
            fifo_rd = 1; @(negedge clk); fifo_rd = 0;
        end
    endtask

    task automatic send_bits(int n);
        core_busy = 1;
        for (int i = 0; i < n; i++) begin
            ks_valid = 1; ks_bit = 1'($urandom);
            @(negedge clk);
            if (i % 41 == 7) begin ks_valid = 0; @(negedge clk); end
        end
        ks_valid = 0; core_busy = 0;
    endtask

    initial begin
        tag = "R1"; idle(3); rst_n = 1; idle(2);
        tag = "R5"; wr(64'h0000_0000_0000_00D3, 0); idle(2);
        tag = "R2"; wr(64'h0000_0000_0000_0004, 0); idle(1);
        wr(64'h8000_0000_0000_0000, 0); idle(2);
        tag = "R1"; do_reset();
        tag = "R3"; wr(64'h0000_0000_0000_00A0, 0); idle(2);
        tag = "R1"; do_reset();
        tag = "R4"; wr(64'h0000_0000_0000_0001, 0); wr(64'h0000_0000_0000_00A4, 1); idle(2);
        tag = "R11"; reinit = 1; @(negedge clk); reinit = 0; idle(2);
        tag = "R10"; idle(3);
        tag = "R1"; do_reset();
        tag = "R9"; rd(1); idle(2);
        tag = "R6"; wr(64'h0000_0000_0000_0080, 0); send_bits(228); idle(1); rd(4); idle(1);
        tag = "R7"; wr(64'h0000_0000_0000_0002, 0); send_bits(228); idle(1); rd(4); idle(1);
        tag = "R8"; send_bits(228); wr(64'h0000_0000_0000_0080, 0); send_bits(228); idle(1);
        fifo_rd = 1; ks_valid = 0; idle(8); fifo_rd = 0; idle(1);
        tag = "R11"; send_bits(30); rd(1);
        wr(64'h0000_0000_0000_0080, 0); send_bits(100);
        reinit = 1; fifo_rd = 1; ks_valid = 1; cfg_wr_en = 1; cfg_wr_data = 64'h1;
        @(negedge clk);
        reinit = 0; fifo_rd = 0; ks_valid = 0; cfg_wr_en = 0;
        idle(2); send_bits(228); rd(4); idle(2);
        tag = "R10"; rd(1); idle(2);
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule